// File: doc/BRIEF.md
# System-Management Interrupt Sequencer

This block runs the bus-side handshake for a system-management interrupt on a simple processor bus model. A request can come from two places. One is the shared active-low interrupt line. The other is a software trigger, which counts only while its enable bit is set. The request is held pending until the strobe that marks the end of the current bus cycle or instruction. At that strobe the block takes ownership of the line and pulls it low. It then runs a fixed burst of 114 state-save transfers into a separate management address space. These transfers use their own address strobe and ready signal.

After the save burst, the block presents the management entry fetch address and raises the interrupt mask. It then waits for a restore command that carries a valid base. The restore runs the same 114 transfers, visiting the same addresses in the same order. When the restore ends, the block drives the line high for two cycles and then releases it. Register contents, data movement and instruction decode belong to the surrounding core.

Top module: `smi_sequencer`

## Requirements
- R1: After reset, `phase` is 0, `lineOe` is 0, `mgmtAds` is 0 and `intMask` is 0.
- R2: A request is taken only at a cycle where `opDone` is high. Until then the block stays in phase 0 and does not drive the line. With `opDone` high, the next cycle shows phase 1. This holds whether the request arrives in that same cycle or earlier.
- R3: A hardware request is a low level on `irqLineIn`. A software request is `swSmiOp` high while `swSmiEn` is high. `swSmiOp` with `swSmiEn` low is ignored. A software pulse is remembered until `opDone`.
- R4: From the first save cycle until the last restore transfer is acknowledged, `lineOe` is 1 and `lineDrive` is 0.
- R5: The save phase makes exactly 114 transfers. Each transfer raises `mgmtAds` for one cycle. The next strobe comes in the cycle after the `mgmtRdy` that acknowledges the previous one. `mgmtRdy` during a strobe cycle is ignored.
- R6: Transfer i uses the address 0x060000 + 2·i for i < 102, and 0x060100 + 2·(i − 102) for i ≥ 102.
- R7: After the last save acknowledgement, `phase` is 2, `mgmtAddr` is 0xFFFFF0 and `intMask` is 1.
- R8: The restore starts only when `restoreCmd` and `restoreBaseOk` are both high in phase 2. A command without a valid base is ignored, and so is a command in phase 0.
- R9: The restore makes 114 transfers. Their addresses and handshake match the save.
- R10: After the last restore acknowledgement, `lineOe` is 1 and `lineDrive` is 1 for exactly two cycles. Then `lineOe` is 0 and `phase` is 0.
- R11: `phase` encodes idle as 0, save as 1, execute as 2 and restore as 3. The restore phase includes the two release cycles. `intMask` is 1 whenever `phase` is not 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLineIn | input | 1 | Sampled level of the shared interrupt line, active low |
| opDone | input | 1 | Current bus cycle or instruction has completed |
| swSmiOp | input | 1 | Software interrupt instruction executed |
| swSmiEn | input | 1 | Enable bit for the software interrupt |
| mgmtRdy | input | 1 | Management-space transfer acknowledge |
| restoreCmd | input | 1 | Restore instruction executed |
| restoreBaseOk | input | 1 | Restore base address is valid and does not cross a 64K boundary |
| mgmtAds | output | 1 | Management-space address strobe, one cycle per transfer |
| mgmtAddr | output | 24 | Management-space address |
| lineOe | output | 1 | Block drives the interrupt line |
| lineDrive | output | 1 | Value driven on the interrupt line while `lineOe` is high |
| phase | output | 2 | 0 idle, 1 save, 2 execute, 3 restore |
| intMask | output | 1 | Maskable and non-maskable interrupts are blocked |

## Verification
The assertions expect a hardware request to stay low until the first save strobe. They also expect each strobe to be answered by one `mgmtRdy`, and the restore command to be pulsed only in the execute phase. The bench pin model follows these rules. It joins the block's drive with an external open-drain driver, and the external driver lets go at the first strobe. A bench memory responder raises `mgmtRdy` only in the wait window, after a random delay. It may also raise it during a strobe cycle, where it must be ignored. Stray restore commands without a valid base are applied only in the idle and execute phases, where the requirements say they have no effect.

// File: rtl/smi_pkg.sv
package smi_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_SAVE    = 2'd1,
    PH_EXEC    = 2'd2,
    PH_RESTORE = 2'd3
  } phase_e;

  typedef struct packed {
    logic clrIdx;
    logic incIdx;
    logic selEntry;
  } dpStrobe_t;

endpackage

// File: rtl/smi_xfer_path.sv
module smi_xfer_path
  import smi_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_A  = 102,
  parameter int unsigned CNT_B  = 12,
  parameter int unsigned BASE_A = 32'h060000,
  parameter int unsigned BASE_B = 32'h060100,
  parameter int unsigned STEP   = 2,
  parameter int unsigned ENTRY  = 32'hFFFFF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strb,
  output logic              lastXfer,
  output logic [ADDR_W-1:0] mgmtAddr
);

  localparam int unsigned TOTAL = CNT_A + CNT_B;
  localparam int unsigned IDX_W = $clog2(TOTAL);
  localparam int unsigned HI_A  = BASE_A + (CNT_A - 1) * STEP;
  localparam int unsigned HI_B  = BASE_B + (CNT_B - 1) * STEP;

  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] xferAddr;

  always_ff @(posedge clk) begin
    if (!rstN)            idx <= '0;
    else if (strb.clrIdx) idx <= '0;
    else if (strb.incIdx) idx <= idx + 1'b1;
  end

  assign lastXfer = (idx == IDX_W'(TOTAL - 1));

  always_comb begin
    if (idx < IDX_W'(CNT_A))
      xferAddr = ADDR_W'(BASE_A) + ADDR_W'(idx) * ADDR_W'(STEP);
    else
      xferAddr = ADDR_W'(BASE_B) + ADDR_W'(idx - IDX_W'(CNT_A)) * ADDR_W'(STEP);
  end

  assign mgmtAddr = strb.selEntry ? ADDR_W'(ENTRY) : xferAddr;

  AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    idx <= IDX_W'(TOTAL - 1)); // R5

  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incIdx && !strb.clrIdx) |=> idx == $past(idx) + 1'b1); // R5

  AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    !strb.selEntry |-> ((mgmtAddr >= ADDR_W'(BASE_A) && mgmtAddr <= ADDR_W'(HI_A)) ||
                        (mgmtAddr >= ADDR_W'(BASE_B) && mgmtAddr <= ADDR_W'(HI_B)))); // R6

endmodule

// File: rtl/smi_seq_ctrl.sv
module smi_seq_ctrl
  import smi_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      irqLineIn,
  input  logic      opDone,
  input  logic      swSmiOp,
  input  logic      swSmiEn,
  input  logic      mgmtRdy,
  input  logic      restoreCmd,
  input  logic      restoreBaseOk,
  input  logic      lastXfer,
  output dpStrobe_t strb,
  output logic      mgmtAds,
  output logic      lineOe,
  output logic      lineDrive,
  output phase_e    phase,
  output logic      intMask
);

  typedef enum logic [2:0] {
    C_IDLE, C_SAVE_ADS, C_SAVE_WAIT, C_EXEC,
    C_RST_ADS, C_RST_WAIT, C_REL1, C_REL2
  } ctrl_e;

  ctrl_e state, stateNxt;
  logic  pending;
  logic  reqNow;

  assign reqNow = !irqLineIn || (swSmiOp && swSmiEn);

  always_ff @(posedge clk) begin
    if (!rstN)               pending <= 1'b0;
    else if (state == C_IDLE) pending <= (pending || reqNow) && !opDone;
    else                     pending <= 1'b0;
  end

  always_comb begin
    stateNxt      = state;
    strb          = '0;
    strb.selEntry = (state == C_EXEC);
    unique case (state)
      C_IDLE:
        if (opDone && (reqNow || pending)) begin
          stateNxt    = C_SAVE_ADS;
          strb.clrIdx = 1'b1;
        end
      C_SAVE_ADS: stateNxt = C_SAVE_WAIT;
      C_SAVE_WAIT:
        if (mgmtRdy) begin
          if (lastXfer) stateNxt = C_EXEC;
          else begin
            stateNxt    = C_SAVE_ADS;
            strb.incIdx = 1'b1;
          end
        end
      C_EXEC:
        if (restoreCmd && restoreBaseOk) begin
          stateNxt    = C_RST_ADS;
          strb.clrIdx = 1'b1;
        end
      C_RST_ADS: stateNxt = C_RST_WAIT;
      C_RST_WAIT:
        if (mgmtRdy) begin
          if (lastXfer) stateNxt = C_REL1;
          else begin
            stateNxt    = C_RST_ADS;
            strb.incIdx = 1'b1;
          end
        end
      C_REL1: stateNxt = C_REL2;
      C_REL2: stateNxt = C_IDLE;
      default: stateNxt = C_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= C_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    unique case (state)
      C_IDLE:                  phase = PH_IDLE;
      C_SAVE_ADS, C_SAVE_WAIT: phase = PH_SAVE;
      C_EXEC:                  phase = PH_EXEC;
      default:                 phase = PH_RESTORE;
    endcase
  end

  assign mgmtAds   = (state == C_SAVE_ADS) || (state == C_RST_ADS);
  assign lineOe    = (state != C_IDLE);
  assign lineDrive = (state == C_REL1) || (state == C_REL2);
  assign intMask   = (state != C_IDLE);

  AST_ADS_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    mgmtAds |=> !mgmtAds); // R5

  AST_ENTER_ON_DONE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lineOe) |-> $past(opDone)); // R2

  AST_RELEASE_TWO_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lineOe) |-> ($past(lineDrive) && $past(lineDrive, 2))); // R10

  AST_EXEC_AFTER_SAVE: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_EXEC && $past(phase) != PH_EXEC) |-> $past(phase) == PH_SAVE); // R11

  AST_RESTORE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_RESTORE && $past(phase) == PH_EXEC) |-> $past(restoreCmd && restoreBaseOk)); // R8

endmodule

// File: rtl/smi_sequencer.sv
module smi_sequencer
  import smi_pkg::*;
#(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned CNT_A  = 102,
  parameter int unsigned CNT_B  = 12,
  parameter int unsigned BASE_A = 32'h060000,
  parameter int unsigned BASE_B = 32'h060100,
  parameter int unsigned STEP   = 2,
  parameter int unsigned ENTRY  = 32'hFFFFF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              irqLineIn,
  input  logic              opDone,
  input  logic              swSmiOp,
  input  logic              swSmiEn,
  input  logic              mgmtRdy,
  input  logic              restoreCmd,
  input  logic              restoreBaseOk,
  output logic              mgmtAds,
  output logic [ADDR_W-1:0] mgmtAddr,
  output logic              lineOe,
  output logic              lineDrive,
  output logic [1:0]        phase,
  output logic              intMask
);

  dpStrobe_t strb;
  logic      lastXfer;
  phase_e    phaseInt;

  smi_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .irqLineIn(irqLineIn), .opDone(opDone),
    .swSmiOp(swSmiOp), .swSmiEn(swSmiEn), .mgmtRdy(mgmtRdy),
    .restoreCmd(restoreCmd), .restoreBaseOk(restoreBaseOk),
    .lastXfer(lastXfer), .strb(strb), .mgmtAds(mgmtAds), .lineOe(lineOe),
    .lineDrive(lineDrive), .phase(phaseInt), .intMask(intMask)
  );

  smi_xfer_path #(
    .ADDR_W(ADDR_W), .CNT_A(CNT_A), .CNT_B(CNT_B), .BASE_A(BASE_A),
    .BASE_B(BASE_B), .STEP(STEP), .ENTRY(ENTRY)
  ) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .lastXfer(lastXfer), .mgmtAddr(mgmtAddr)
  );

  assign phase = phaseInt;

  AST_ENTRY_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (phaseInt == PH_EXEC) |-> mgmtAddr == ADDR_W'(ENTRY)); // R7

  AST_LINE_LOW_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    (phaseInt == PH_SAVE || phaseInt == PH_EXEC) |-> (lineOe && !lineDrive)); // R4

endmodule

// File: tb/sim_smi_sequencer.sv
module sim_smi_sequencer;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, extDrvN, opDone, swSmiOp, swSmiEn, mgmtRdy, restoreCmd, restoreBaseOk;
  logic mgmtAds, lineOe, lineDrive, intMask;
  logic [23:0] mgmtAddr;
  logic [1:0]  phase;
  wire         irqPin;

  assign irqPin = (lineOe ? lineDrive : 1'b1) & extDrvN;

  smi_sequencer u0 (
    .clk(clk), .rstN(rstN), .irqLineIn(irqPin), .opDone(opDone),
    .swSmiOp(swSmiOp), .swSmiEn(swSmiEn), .mgmtRdy(mgmtRdy),
    .restoreCmd(restoreCmd), .restoreBaseOk(restoreBaseOk),
    .mgmtAds(mgmtAds), .mgmtAddr(mgmtAddr), .lineOe(lineOe),
    .lineDrive(lineDrive), .phase(phase), .intMask(intMask)
  );

  int vecs = 0;
  int errs = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int expAddr(input int i);
    return (i < 102) ? 32'h060000 + 2 * i : 32'h060100 + 2 * (i - 102);
  endfunction

  task automatic burst(input bit isRst);
    string rq = isRst ? "R9" : "R6";
    int expPh = isRst ? 3 : 1;
    for (int i = 0; i < 114; i++) begin
      chk(mgmtAds == 1'b1, "R5", "strobe", mgmtAds, 1);
      chk(mgmtAddr == expAddr(i), rq, "address", mgmtAddr, expAddr(i));
      chk(phase == expPh, "R11", "phase in burst", phase, expPh);
      chk(lineOe && !lineDrive, "R4", "line low", {lineOe, lineDrive}, 2'b10);
      if (i == 0) extDrvN = 1'b1;
      mgmtRdy = 1'($urandom_range(0, 1));
      @(negedge clk);
      chk(mgmtAds == 1'b0, "R5", "strobe width", mgmtAds, 0);
      mgmtRdy = 1'b0;
      repeat ($urandom_range(0, 3)) @(negedge clk);
      mgmtRdy = 1'b1;
      @(negedge clk);
      mgmtRdy = 1'b0;
    end
  endtask

  task automatic runSmi(input bit sw, input int waitCycles, input int stray);
    swSmiEn = 1'b1;
    swSmiOp = sw;
    extDrvN = sw ? 1'b1 : 1'b0;
    opDone  = (waitCycles == 0);
    for (int k = 0; k < waitCycles; k++) begin
      @(negedge clk);
      swSmiOp = 1'b0;
      chk(phase == 0 && !lineOe, "R2", "wait for completion", {phase, lineOe}, 0);
      if (k == waitCycles - 1) opDone = 1'b1;
    end
    @(negedge clk);
    opDone = 1'b0; swSmiOp = 1'b0;
    chk(phase == 1, "R2", "entry phase", phase, 1);
    chk(lineOe && !lineDrive, "R4", "line low at entry", {lineOe, lineDrive}, 2'b10);
    burst(1'b0);
    chk(phase == 2, "R7", "exec phase", phase, 2);
    chk(mgmtAddr == 24'hFFFFF0, "R7", "entry address", mgmtAddr, 24'hFFFFF0);
    chk(intMask == 1'b1, "R7", "mask", intMask, 1);
    chk(lineOe && !lineDrive, "R4", "line low in exec", {lineOe, lineDrive}, 2'b10);
    for (int k = 0; k < stray; k++) begin
      restoreCmd = 1'b1; restoreBaseOk = 1'b0;
      @(negedge clk);
      restoreCmd = 1'b0;
      chk(phase == 2, "R8", "restore without base", phase, 2);
    end
    restoreCmd = 1'b1; restoreBaseOk = 1'b1;
    @(negedge clk);
    restoreCmd = 1'b0; restoreBaseOk = 1'b0;
    chk(phase == 3, "R8", "restore start", phase, 3);
    burst(1'b1);
    for (int k = 0; k < 2; k++) begin
      chk(lineOe && lineDrive && irqPin, "R10", "release high",
          {lineOe, lineDrive, irqPin}, 3'b111);
      chk(phase == 3, "R11", "phase in release", phase, 3);
      @(negedge clk);
    end
    chk(!lineOe, "R10", "line floated", lineOe, 0);
    chk(phase == 0 && !intMask, "R11", "back to idle", {phase, intMask}, 0);
  endtask

  initial begin
    #2000000;
    errs++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rstN = 1'b0; extDrvN = 1'b1; opDone = 1'b0; swSmiOp = 1'b0; swSmiEn = 1'b0;
    mgmtRdy = 1'b0; restoreCmd = 1'b0; restoreBaseOk = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(phase == 0 && !lineOe && !mgmtAds && !intMask, "R1", "reset state",
        {phase, lineOe, mgmtAds, intMask}, 0);

    // R3: software op without enable is ignored
    swSmiEn = 1'b0; swSmiOp = 1'b1; opDone = 1'b1;
    @(negedge clk);
    swSmiOp = 1'b0;
    @(negedge clk);
    opDone = 1'b0;
    chk(phase == 0 && !lineOe, "R3", "disabled software request", {phase, lineOe}, 0);

    // R8: restore command in idle is ignored
    restoreCmd = 1'b1; restoreBaseOk = 1'b1;
    @(negedge clk);
    restoreCmd = 1'b0; restoreBaseOk = 1'b0;
    chk(phase == 0 && !mgmtAds, "R8", "restore in idle", {phase, mgmtAds}, 0);

    runSmi(1'b0, 3, 1);   // hardware request, delayed completion
    runSmi(1'b1, 0, 0);   // R3 software request with same-cycle completion
    runSmi(1'b1, 4, 2);   // R3 software pulse remembered until completion
    for (int r = 0; r < 3; r++)
      runSmi(1'($urandom_range(0, 1)), $urandom_range(0, 4), $urandom_range(0, 2));

    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

endmodule